// File: doc/BRIEF.md
# Hybrid Fast/Slow Way Tag Lookup

This block performs the tag lookup for one bank of a set-associative cache. Two fast ways are always present. An extension of thirty-two slow ways can be switched on or off at run time. The tags of the slow ways are held in a second tag array that belongs to the same bank. While the extension is on, one lookup compares the tags of every enabled way at once. The block then reports hit or miss, the way involved, and whether that way is fast or slow. A response for a slow-way hit arrives later than any other response, and the extra delay is set by an input.

A hit in a slow way promotes the line into a fast way and makes it the most recently used line there. The fast line it displaces drops into the slow slot that was just freed. On a miss the new tag is written into a fast way. The fast line that leaves is demoted into a slow way in round-robin order if the extension is on, and is dropped if it is off. Switching the extension on or off never changes which set an index selects. Turning the extension off invalidates every slow-way tag, so those tags cannot hit again after the extension is turned back on. Data storage is represented only by way numbers.

Requests and responses each use a valid/ready handshake. A request is accepted only while no lookup is outstanding. `req_ready` is low from acceptance until the response has been taken. A response, once valid, holds every field stable until `rsp_ready` is seen high. The extension enable and the latency setting are plain level inputs and are sampled on the cycle a request is accepted.

Top module: `hybrid_way_lookup`

## Requirements
- R1: After reset no way holds a valid tag, `req_ready` is 1 and `rsp_valid` is 0, so the first lookup of any tag is a miss.
- R2: A lookup reports a hit when any enabled way of the addressed set holds a valid copy of the tag, all ways being compared in a single lookup. `rsp_way` numbers the fast ways 0 and 1 and the slow ways 2 to 33. `rsp_slow` is 1 exactly for hits in ways 2 to 33.
- R3: `rsp_valid` rises SRAM_LAT cycles after the accepting clock edge for a fast hit or a miss, and SRAM_LAT plus `dram_lat` cycles after it for a slow hit.
- R4: `req_ready` is 0 from acceptance until the response handshake. While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields stay unchanged.
- R5: While `dram_en` is 0, the slow ways never hit, and a miss drops the displaced fast line instead of demoting it.
- R6: Every cycle with `dram_en` at 0 invalidates all slow-way tags. A tag that was resident only in a slow way misses after the extension is enabled again.
- R7: Fast-way lines stay valid and keep hitting across changes of `dram_en`.
- R8: A slow hit swaps the line with the current fast victim way. The next lookup of the same tag is then a fast hit in that way, and the displaced tag hits in the slow way that was vacated.
- R9: When the extension is on, a miss demotes the valid displaced fast line into the slow way given by a per-set pointer. The pointer advances 0, 1, ..., 31 and then wraps to 0.
- R10: Each set's fast victim is the fast way after the one most recently hit, filled or promoted into (way 1 after way 0, way 0 after way 1). On a miss `rsp_way` reports the fast way that was filled.
- R11: Each set keeps its own tags and pointers. A lookup in one set neither sees nor changes another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dram_en | input | 1 | Enables the slow-way extension |
| dram_lat | input | 4 | Extra response delay for a slow-way hit, in cycles |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can accept a lookup |
| req_set | input | 2 | Set index of the request |
| req_tag | input | 10 | Tag to look up |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | 1 for a hit, 0 for a miss |
| rsp_slow | output | 1 | Hit was in a slow way |
| rsp_way | output | 6 | Way that hit, or the fast way filled on a miss |

## Verification
Two functions can act in the same cycle: a response held back by a stalled `rsp_ready`, and a change of `dram_en`. The bench provokes this in the random phase by holding `rsp_ready` low for several cycles and toggling the extension between requests. It then checks that the held fields stay stable and that the next lookup neither hits a slow way nor demotes into one. The bench also checks, one clock at a time, the exact cycle in which `rsp_valid` rises for every promotion, and compares it with a behavioural model.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP} lk_state_e;
  typedef enum logic [1:0] {UPD_NONE, UPD_TOUCH, UPD_PROMOTE, UPD_FILL} upd_op_e;
endpackage

// File: rtl/hwl_tag_match.sv
module hwl_tag_match #(
  parameter int SW    = 2,
  parameter int DW    = 32,
  parameter int TAG_W = 10,
  localparam int SW_W = $clog2(SW),
  localparam int DW_W = $clog2(DW)
) (
  input  logic [SW-1:0][TAG_W-1:0] s_tag,
  input  logic [SW-1:0]            s_vld,
  input  logic [DW-1:0][TAG_W-1:0] d_tag,
  input  logic [DW-1:0]            d_vld,
  input  logic                     dram_en,
  input  logic [TAG_W-1:0]         tag,
  output logic                     s_hit,
  output logic [SW_W-1:0]          s_way,
  output logic                     d_hit,
  output logic [DW_W-1:0]          d_way
);
  logic [SW-1:0] s_eq;
  logic [DW-1:0] d_eq;

  // one comparator per way, all evaluated together
  for (genvar g = 0; g < SW; g++) begin : g_fast_cmp
    assign s_eq[g] = s_vld[g] && (s_tag[g] == tag);
  end
  for (genvar g = 0; g < DW; g++) begin : g_slow_cmp
    assign d_eq[g] = dram_en && d_vld[g] && (d_tag[g] == tag);
  end

  assign s_hit = |s_eq;
  assign d_hit = |d_eq;

  // lowest matching way wins
  always_comb begin
    s_way = '0;
    for (int i = SW - 1; i >= 0; i--) begin
      if (s_eq[i]) s_way = SW_W'(i);
    end
  end

  always_comb begin
    d_way = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (d_eq[i]) d_way = DW_W'(i);
    end
  end
endmodule

// File: rtl/hwl_tag_store.sv
module hwl_tag_store
  import hwl_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int SW    = 2,
  parameter int DW    = 32,
  parameter int TAG_W = 10,
  localparam int IDX_W = $clog2(SETS),
  localparam int SW_W  = $clog2(SW),
  localparam int DW_W  = $clog2(DW)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dram_en,
  input  logic [IDX_W-1:0]         set,
  input  upd_op_e                  op,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic [SW_W-1:0]          hit_sway,
  input  logic [DW_W-1:0]          hit_dway,
  output logic [SW-1:0][TAG_W-1:0] rd_s_tag,
  output logic [SW-1:0]            rd_s_vld,
  output logic [DW-1:0][TAG_W-1:0] rd_d_tag,
  output logic [DW-1:0]            rd_d_vld,
  output logic [SW_W-1:0]          rd_vict
);
  logic [TAG_W-1:0] s_tag_q [SETS][SW];
  logic             s_vld_q [SETS][SW];
  logic [TAG_W-1:0] d_tag_q [SETS][DW];
  logic             d_vld_q [SETS][DW];
  logic [SW_W-1:0]  vict_q  [SETS];
  logic [DW_W-1:0]  dptr_q  [SETS];

  logic [DW_W-1:0]  dptr_sel;

  function automatic logic [SW_W-1:0] nxt_s(input logic [SW_W-1:0] w);
    return (w == SW_W'(SW - 1)) ? '0 : w + 1'b1;
  endfunction

  function automatic logic [DW_W-1:0] nxt_d(input logic [DW_W-1:0] w);
    return (w == DW_W'(DW - 1)) ? '0 : w + 1'b1;
  endfunction

  assign rd_vict  = vict_q[set];
  assign dptr_sel = dptr_q[set];

  always_comb begin
    for (int i = 0; i < SW; i++) begin
      rd_s_tag[i] = s_tag_q[set][i];
      rd_s_vld[i] = s_vld_q[set][i];
    end
    for (int i = 0; i < DW; i++) begin
      rd_d_tag[i] = d_tag_q[set][i];
      rd_d_vld[i] = d_vld_q[set][i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vict_q[s] <= '0;
        dptr_q[s] <= '0;
        for (int i = 0; i < SW; i++) begin
          s_tag_q[s][i] <= '0;
          s_vld_q[s][i] <= 1'b0;
        end
        for (int i = 0; i < DW; i++) begin
          d_tag_q[s][i] <= '0;
          d_vld_q[s][i] <= 1'b0;
        end
      end
    end else begin
      unique case (op)
        UPD_TOUCH: vict_q[set] <= nxt_s(hit_sway);
        UPD_PROMOTE: begin
          // exchange the slow hit with the current fast victim
          s_tag_q[set][rd_vict]  <= wr_tag;
          s_vld_q[set][rd_vict]  <= 1'b1;
          d_tag_q[set][hit_dway] <= s_tag_q[set][rd_vict];
          d_vld_q[set][hit_dway] <= s_vld_q[set][rd_vict];
          vict_q[set]            <= nxt_s(rd_vict);
        end
        UPD_FILL: begin
          if (dram_en && s_vld_q[set][rd_vict]) begin
            d_tag_q[set][dptr_sel] <= s_tag_q[set][rd_vict];
            d_vld_q[set][dptr_sel] <= 1'b1;
            dptr_q[set]            <= nxt_d(dptr_sel);
          end
          s_tag_q[set][rd_vict] <= wr_tag;
          s_vld_q[set][rd_vict] <= 1'b1;
          vict_q[set]           <= nxt_s(rd_vict);
        end
        default: ;
      endcase
      // extension off: slow tags are flushed, overriding any update
      if (!dram_en) begin
        for (int s = 0; s < SETS; s++) begin
          for (int i = 0; i < DW; i++) d_vld_q[s][i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/hwl_lat_ctl.sv
module hwl_lat_ctl
  import hwl_pkg::*;
#(
  parameter int LAT_W    = 4,
  parameter int SRAM_LAT = 2,
  localparam int CNT_W   = $clog2(SRAM_LAT + (1 << LAT_W) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             slow,
  input  logic [LAT_W-1:0] dram_lat,
  input  logic             rsp_ready,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic             accept
);
  lk_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lat;

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign accept    = req_valid && req_ready;
  assign lat       = slow ? CNT_W'(SRAM_LAT) + CNT_W'(dram_lat) : CNT_W'(SRAM_LAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_WAIT;
          cnt_q   <= lat - 1'b1;
        end
        ST_WAIT: begin
          if (cnt_q == '0) state_q <= ST_RESP;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hybrid_way_lookup.sv
module hybrid_way_lookup
  import hwl_pkg::*;
#(
  parameter int SETS      = 4,
  parameter int SRAM_WAYS = 2,
  parameter int DRAM_WAYS = 32,
  parameter int TAG_W     = 10,
  parameter int SRAM_LAT  = 2,
  parameter int LAT_W     = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(SRAM_WAYS + DRAM_WAYS),
  localparam int SW_W  = $clog2(SRAM_WAYS),
  localparam int DW_W  = $clog2(DRAM_WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dram_en,
  input  logic [LAT_W-1:0] dram_lat,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_set,
  input  logic [TAG_W-1:0] req_tag,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic             rsp_slow,
  output logic [WAY_W-1:0] rsp_way
);
  logic [SRAM_WAYS-1:0][TAG_W-1:0] s_tag;
  logic [SRAM_WAYS-1:0]            s_vld;
  logic [DRAM_WAYS-1:0][TAG_W-1:0] d_tag;
  logic [DRAM_WAYS-1:0]            d_vld;
  logic [SW_W-1:0]                 vict, s_way;
  logic [DW_W-1:0]                 d_way;
  logic                            s_hit, d_hit, slow_hit, accept;
  upd_op_e                         op;
  logic [WAY_W-1:0]                way_now;

  hwl_tag_store #(
    .SETS(SETS), .SW(SRAM_WAYS), .DW(DRAM_WAYS), .TAG_W(TAG_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .dram_en(dram_en), .set(req_set), .op(op),
    .wr_tag(req_tag), .hit_sway(s_way), .hit_dway(d_way),
    .rd_s_tag(s_tag), .rd_s_vld(s_vld), .rd_d_tag(d_tag), .rd_d_vld(d_vld),
    .rd_vict(vict)
  );

  hwl_tag_match #(
    .SW(SRAM_WAYS), .DW(DRAM_WAYS), .TAG_W(TAG_W)
  ) u_match (
    .s_tag(s_tag), .s_vld(s_vld), .d_tag(d_tag), .d_vld(d_vld),
    .dram_en(dram_en), .tag(req_tag),
    .s_hit(s_hit), .s_way(s_way), .d_hit(d_hit), .d_way(d_way)
  );

  hwl_lat_ctl #(
    .LAT_W(LAT_W), .SRAM_LAT(SRAM_LAT)
  ) u_lat (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .slow(slow_hit),
    .dram_lat(dram_lat), .rsp_ready(rsp_ready), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .accept(accept)
  );

  assign slow_hit = d_hit && !s_hit;

  always_comb begin
    op      = UPD_NONE;
    way_now = WAY_W'(vict);
    if (accept) begin
      if (s_hit) begin
        op      = UPD_TOUCH;
        way_now = WAY_W'(s_way);
      end else if (d_hit) begin
        op      = UPD_PROMOTE;
        way_now = WAY_W'(SRAM_WAYS) + WAY_W'(d_way);
      end else begin
        op      = UPD_FILL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_hit  <= 1'b0;
      rsp_slow <= 1'b0;
      rsp_way  <= '0;
    end else if (accept) begin
      rsp_hit  <= s_hit || d_hit;
      rsp_slow <= slow_hit;
      rsp_way  <= way_now;
    end
  end
endmodule

// File: rtl/hwl_checker.sv
module hwl_checker #(
  parameter int SRAM_WAYS = 2,
  parameter int WAY_W     = 6,
  parameter int SRAM_LAT  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dram_en,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic             rsp_slow,
  input logic [WAY_W-1:0] rsp_way
);
  logic [7:0] since_acc;
  logic       acc_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_acc <= '0;
      acc_off   <= 1'b0;
    end else if (req_valid && req_ready) begin
      since_acc <= '0;
      acc_off   <= !dram_en;
    end else if (since_acc != 8'hff) begin
      since_acc <= since_acc + 1'b1;
    end
  end

  assert_rsp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_slow) && $stable(rsp_way));

  assert_no_accept_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  assert_slow_way_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_slow |-> rsp_hit && (rsp_way >= WAY_W'(SRAM_WAYS)));

  assert_fast_way_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_slow |-> (rsp_way < WAY_W'(SRAM_WAYS)));

  assert_fast_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && !rsp_slow |-> since_acc == 8'(SRAM_LAT));

  assert_off_never_slow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && acc_off |-> !rsp_slow);
endmodule

bind hybrid_way_lookup hwl_checker #(
  .SRAM_WAYS(SRAM_WAYS), .WAY_W(WAY_W), .SRAM_LAT(SRAM_LAT)
) u_hwl_checker (
  .clk(clk), .rst_n(rst_n), .dram_en(dram_en), .req_valid(req_valid),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_hit(rsp_hit), .rsp_slow(rsp_slow), .rsp_way(rsp_way)
);

// File: tb/test_hybrid_way_lookup.sv
module test_hybrid_way_lookup;
  localparam int SETS = 4, SW = 2, DW = 32, NW = SW + DW, SLAT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dram_en = 1'b0;
  logic [3:0] dram_lat = 4'd0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_set = '0;
  logic [9:0] req_tag = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic       rsp_hit, rsp_slow;
  logic [5:0] rsp_way;

  always #5 clk = ~clk;

  hybrid_way_lookup i_hybrid_way_lookup (
    .clk(clk), .rst_n(rst_n), .dram_en(dram_en), .dram_lat(dram_lat),
    .req_valid(req_valid), .req_ready(req_ready), .req_set(req_set),
    .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_slow(rsp_slow), .rsp_way(rsp_way)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_tag [SETS][NW];
  bit m_val [SETS][NW];
  int m_vict [SETS];
  int m_dptr [SETS];
  int m_state = 0, m_cnt = 0;
  bit e_hit, e_slow;
  int e_way;
  bit g_hit, g_slow;
  int g_way;

  task automatic model_step();
    if (m_state == 0) begin
      if (req_valid) begin
        int s, t, v, w, tt;
        bit h;
        s = req_set; t = req_tag; h = 0; w = 0;
        for (int i = 0; i < SW; i++)
          if (!h && m_val[s][i] && m_tag[s][i] == t) begin h = 1; w = i; end
        if (!h && dram_en)
          for (int i = SW; i < NW; i++)
            if (!h && m_val[s][i] && m_tag[s][i] == t) begin h = 1; w = i; end
        v = m_vict[s];
        if (h && w < SW) begin
          m_vict[s] = (w + 1) % SW;
        end else if (h) begin
          tt = m_tag[s][v];
          m_val[s][w] = m_val[s][v];
          m_tag[s][w] = tt;
          m_tag[s][v] = t; m_val[s][v] = 1;
          m_vict[s] = (v + 1) % SW;
        end else begin
          if (dram_en && m_val[s][v]) begin
            m_tag[s][SW + m_dptr[s]] = m_tag[s][v];
            m_val[s][SW + m_dptr[s]] = 1;
            m_dptr[s] = (m_dptr[s] + 1) % DW;
          end
          m_tag[s][v] = t; m_val[s][v] = 1;
          m_vict[s] = (v + 1) % SW;
          w = v;
        end
        e_hit = h; e_way = w; e_slow = h && (w >= SW);
        m_cnt = (e_slow ? SLAT + int'(dram_lat) : SLAT) - 1;
        m_state = 1;
      end
    end else if (m_state == 1) begin
      if (m_cnt == 0) m_state = 2; else m_cnt--;
    end else if (rsp_ready) begin
      m_state = 0;
    end
    if (!dram_en)
      for (int s = 0; s < SETS; s++)
        for (int i = SW; i < NW; i++) m_val[s][i] = 0;
  endtask

  task automatic compare();
    bit ok;
    checks++;
    ok = (req_ready === (m_state == 0)) && (rsp_valid === (m_state == 2));
    if (m_state == 2)
      ok = ok && (rsp_hit === e_hit) && (rsp_slow === e_slow) && (int'(rsp_way) == e_way);
    if (!ok) begin
      fails++;
      $display("FAIL %s: rdy=%0b vld=%0b hit=%0b slow=%0b way=%0d, expected rdy=%0b vld=%0b hit=%0b slow=%0b way=%0d",
               cur_req, req_ready, rsp_valid, rsp_hit, rsp_slow, rsp_way,
               m_state == 0, m_state == 2, e_hit, e_slow, e_way);
    end
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic do_req(input int s, input int t, input int hold);
    int h;
    h = hold;
    req_valid = 1; req_set = 2'(s); req_tag = 10'(t); rsp_ready = 0;
    tick();
    req_valid = 0;
    while (m_state != 0) begin
      if (m_state == 2) begin
        g_hit = rsp_hit; g_slow = rsp_slow; g_way = int'(rsp_way);
        if (h > 0) begin rsp_ready = 0; h--; end else rsp_ready = 1;
      end else rsp_ready = 0;
      tick();
    end
    rsp_ready = 0;
  endtask

  task automatic expect_rsp(input string rq, input bit hit, input bit slow, input int way);
    checks++;
    if (g_hit !== hit || (hit && g_slow !== slow) || (way >= 0 && g_way != way)) begin
      fails++;
      $display("FAIL %s: hit=%0b slow=%0b way=%0d, expected hit=%0b slow=%0b way=%0d",
               rq, g_hit, g_slow, g_way, hit, slow, way);
    end
  endtask

  task automatic set_en(input bit en);
    dram_en = en;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lfsr;
    for (int s = 0; s < SETS; s++) begin
      m_vict[s] = 0; m_dptr[s] = 0;
      for (int i = 0; i < NW; i++) begin m_tag[s][i] = 0; m_val[s][i] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare();                                   // R1 reset state
    cur_req = "R1";
    do_req(0, 1, 0); expect_rsp("R1", 0, 0, 0);

    cur_req = "R2";
    dram_en = 1; dram_lat = 4'd5;
    tick();
    do_req(0, 2, 0); expect_rsp("R2", 0, 0, 1);
    do_req(0, 3, 0); expect_rsp("R9", 0, 0, 0);  // tag 1 demoted to slow way 2

    cur_req = "R3";
    do_req(0, 1, 0); expect_rsp("R3", 1, 1, 2);  // slow hit, delayed response
    cur_req = "R8";
    do_req(0, 1, 0); expect_rsp("R8", 1, 0, 1);  // promoted into fast way 1
    do_req(0, 2, 0); expect_rsp("R8", 1, 1, 2);  // displaced tag sits in vacated way

    cur_req = "R10";
    do_req(0, 2, 0); expect_rsp("R10", 1, 0, 0);
    do_req(0, 4, 0); expect_rsp("R10", 0, 0, 1); // victim follows most recent way 0

    cur_req = "R11";
    do_req(1, 2, 0); expect_rsp("R11", 0, 0, 0);

    cur_req = "R4";
    do_req(0, 4, 5); expect_rsp("R4", 1, 0, 1);

    cur_req = "R5";
    set_en(0);
    do_req(0, 3, 0); expect_rsp("R5", 0, 0, 0);
    cur_req = "R7";
    do_req(0, 4, 0); expect_rsp("R7", 1, 0, 1);
    cur_req = "R6";
    set_en(1);
    do_req(0, 1, 0); expect_rsp("R6", 0, 0, 0);
    cur_req = "R7";
    do_req(0, 4, 0); expect_rsp("R7", 1, 0, 1);

    cur_req = "R9";
    dram_lat = 4'd3;
    for (int k = 0; k < 40; k++) do_req(2, 100 + k, 0);
    do_req(2, 106, 0); expect_rsp("R9", 1, 1, 8);
    do_req(2, 100, 0); expect_rsp("R9", 0, 0, -1);
    do_req(2, 106, 0); expect_rsp("R8", 1, 0, 0);

    cur_req = "R2";
    lfsr = 32'h1d3;
    for (int k = 0; k < 300; k++) begin
      lfsr = (lfsr << 1) ^ (((lfsr >> 15) ^ (lfsr >> 13)) & 1);
      lfsr = lfsr & 16'hffff;
      if ((lfsr & 15) == 3) set_en(~dram_en);
      dram_lat = 4'(1 + ((lfsr >> 4) % 15));
      do_req((lfsr >> 2) & 3, (lfsr >> 8) & 15, (lfsr >> 12) & 3);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule